// File: doc/BRIEF.md
# Completion Queue Entry Poster with Phase Tag

This block sits on the controller side of a command queue pair and posts 16-byte completion entries into a circular completion ring held in host memory. Each completion request carries two result dwords, the identifier of the submission queue it belongs to, the command identifier and the status fields. The block adds the current submission-queue head and the phase tag, then emits one 128-bit memory write aimed at the tail slot of the ring.

The host consumes entries and reports progress by writing a new head index to a head doorbell. The phase tag starts at 1 and inverts each time the tail wraps from the last slot back to slot 0. A host can therefore tell fresh entries from entries left over from the previous lap without clearing slots. One slot always stays empty, so a ring of DEPTH slots holds at most DEPTH-1 unconsumed entries. While the ring is full, completion requests are held off through the ready signal of a valid/ready handshake.

Top module: `cqw_top`

## Requirements
- R1: After reset, req_ready is 1 and wr_valid is 0. The first accepted entry goes to slot 0 with phase 1.
- R2: The written entry is laid out as follows. [31:0] is result dword 0. [63:32] is result dword 1. [79:64] is the submission head. [95:80] is the submission queue id. [111:96] is the command identifier. [112] is the phase. [120:113] is the status code. [123:121] is the status code type. [125:124] is the retry hint. [126] is the more bit. [127] is the do-not-retry bit.
- R3: A request accepted at a clock edge (req_valid and req_ready both high) produces exactly one write, with wr_valid high for the following cycle. The write address is cq_base + 16 × tail slot.
- R4: Each accepted request advances the tail by one slot. After slot DEPTH-1 the tail goes back to slot 0.
- R5: The phase written is 1 during the first lap and inverts each time the tail wraps from slot DEPTH-1 to slot 0.
- R6: The ring is full when the slot after the tail equals the head. While full, req_ready is 0, a valid request is not accepted, and no write is produced. The ring holds at most DEPTH-1 entries.
- R7: A doorbell write (db_valid high at an edge) sets the head to db_head. req_ready reflects the new head from the cycle after that edge.
- R8: A doorbell whose index is DEPTH or larger is ignored, and the head keeps its value.
- R9: A doorbell that would move the head past the tail is ignored. The test is that the forward distance from the old head exceeds the number of entries held before that cycle.
- R10: A post and a valid doorbell in the same cycle both take effect.
- R11: The submission head field carries the value on sq_head in the cycle the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cq_base | input | ADDR_W | Byte address of ring slot 0 |
| req_valid | input | 1 | Completion request present |
| req_ready | output | 1 | Request can be accepted (ring not full) |
| req_res0 | input | 32 | Command-specific result dword 0 |
| req_res1 | input | 32 | Command-specific result dword 1 |
| req_sqid | input | 16 | Submission queue id |
| req_cid | input | 16 | Command identifier |
| req_sc | input | 8 | Status code |
| req_sct | input | 3 | Status code type |
| req_crd | input | 2 | Retry delay hint |
| req_more | input | 1 | More-information hint |
| req_dnr | input | 1 | Do-not-retry flag |
| sq_head | input | 16 | Current submission queue head |
| db_valid | input | 1 | Head doorbell write strobe |
| db_head | input | IDX_W | New head index from the host |
| wr_valid | output | 1 | Entry write strobe |
| wr_addr | output | ADDR_W | Entry byte address |
| wr_data | output | 128 | Assembled completion entry |

## Verification
An accepted request produces its write in the cycle after the accepting edge, so wr_valid, wr_addr and wr_data are due one edge after the handshake. A doorbell, or a post that fills the ring, changes req_ready after that same edge and no sooner. The bench drives every input on the falling edge and samples req_ready before the rising edge that consumes it. It samples the write outputs and the updated ready on the next falling edge, so each check falls exactly one register stage after its stimulus. A bench model of head, tail and phase, computed with modular arithmetic, supplies every expected value across many wrap laps of a ring whose size is not a power of two.

// File: rtl/cqw_pkg.sv
package cqw_pkg;

    localparam int ENTRY_BITS  = 128;
    localparam int ENTRY_SHIFT = 4;   // log2 of 16-byte entry

    typedef struct packed {
        logic [31:0] res0;
        logic [31:0] res1;
        logic [15:0] sqid;
        logic [15:0] cid;
        logic [7:0]  sc;
        logic [2:0]  sct;
        logic [1:0]  crd;
        logic        more;
        logic        dnr;
    } cqw_req_t;

    // Status halfword: phase sits in bit 0
    function automatic logic [15:0] status_half(input cqw_req_t r, input logic phase);
        return {r.dnr, r.more, r.crd, r.sct, r.sc, phase};
    endfunction

endpackage

// File: rtl/cqw_ring.sv
module cqw_ring #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post,
    input  logic             db_valid,
    input  logic [IDX_W-1:0] db_head,
    output logic [IDX_W-1:0] tail,
    output logic             phase,
    output logic             full
);
    localparam int CW = IDX_W + 1;
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(DEPTH - 1);
    localparam logic [CW-1:0]    DEPTH_X = CW'(DEPTH);

    typedef struct packed {
        logic [IDX_W-1:0] tail;
        logic [IDX_W-1:0] head;
        logic             phase;
    } ring_t;

    ring_t ring_d, ring_q;

    logic [IDX_W-1:0] tail_inc;
    logic [CW-1:0]    tail_x, head_x, db_x, occ, adv;
    logic             db_in_range, db_ok;

    always_comb begin
        tail_inc    = (ring_q.tail == LAST) ? '0 : ring_q.tail + 1'b1;
        full        = (tail_inc == ring_q.head);
        tail_x      = {1'b0, ring_q.tail};
        head_x      = {1'b0, ring_q.head};
        db_x        = {1'b0, db_head};
        occ         = (tail_x >= head_x) ? (tail_x - head_x) : (tail_x + DEPTH_X - head_x);
        adv         = (db_x >= head_x) ? (db_x - head_x) : (db_x + DEPTH_X - head_x);
        db_in_range = (db_x < DEPTH_X);
        db_ok       = db_valid && db_in_range && (adv <= occ);

        ring_d = ring_q;
        if (post) begin
            ring_d.tail = tail_inc;
            if (ring_q.tail == LAST) begin
                ring_d.phase = ~ring_q.phase;
            end
        end
        if (db_ok) begin
            ring_d.head = db_head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '{tail: '0, head: '0, phase: 1'b1};
        end else begin
            ring_q <= ring_d;
        end
    end

    assign tail  = ring_q.tail;
    assign phase = ring_q.phase;

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_q.tail < DEPTH) && (ring_q.head < DEPTH));

    // R5
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post && ring_q.tail == LAST) |=> (ring_q.phase != $past(ring_q.phase)));

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(post && ring_q.tail == LAST) |=> $stable(ring_q.phase));

    // R6
    no_post_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !post);

    // R8
    bad_db_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && !db_in_range) |=> $stable(ring_q.head));

endmodule

// File: rtl/cqw_pack.sv
module cqw_pack
    import cqw_pkg::*;
(
    input  cqw_req_t                req,
    input  logic [15:0]             sqhd,
    input  logic                    phase,
    output logic [ENTRY_BITS-1:0]   entry
);
    always_comb begin
        entry = {status_half(req, phase), req.cid, req.sqid, sqhd, req.res1, req.res0};
    end
endmodule

// File: rtl/cqw_top.sv
module cqw_top
    import cqw_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cq_base,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [31:0]           req_res0,
    input  logic [31:0]           req_res1,
    input  logic [15:0]           req_sqid,
    input  logic [15:0]           req_cid,
    input  logic [7:0]            req_sc,
    input  logic [2:0]            req_sct,
    input  logic [1:0]            req_crd,
    input  logic                  req_more,
    input  logic                  req_dnr,
    input  logic [15:0]           sq_head,
    input  logic                  db_valid,
    input  logic [IDX_W-1:0]      db_head,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [ENTRY_BITS-1:0] wr_data
);
    typedef struct packed {
        logic                  valid;
        logic [ADDR_W-1:0]     addr;
        logic [ENTRY_BITS-1:0] data;
    } out_t;

    out_t out_d, out_q;

    cqw_req_t              req;
    logic                  post;
    logic                  full;
    logic                  phase;
    logic [IDX_W-1:0]      tail;
    logic [ENTRY_BITS-1:0] entry;

    assign req = '{res0: req_res0, res1: req_res1, sqid: req_sqid, cid: req_cid,
                   sc: req_sc, sct: req_sct, crd: req_crd, more: req_more, dnr: req_dnr};

    assign req_ready = !full;
    assign post      = req_valid && req_ready;

    cqw_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .post     (post),
        .db_valid (db_valid),
        .db_head  (db_head),
        .tail     (tail),
        .phase    (phase),
        .full     (full)
    );

    cqw_pack u_pack (
        .req   (req),
        .sqhd  (sq_head),
        .phase (phase),
        .entry (entry)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = post;
        if (post) begin
            out_d.addr = cq_base + (ADDR_W'(tail) << ENTRY_SHIFT);
            out_d.data = entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wr_valid = out_q.valid;
    assign wr_addr  = out_q.addr;
    assign wr_data  = out_q.data;

    // R3
    wr_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(req_valid && req_ready));

    // R6
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !wr_valid);

    // R2
    phase_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> (wr_data[112] == $past(phase)));

endmodule

// File: tb/cqw_top_bench.sv
module cqw_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 5;
    localparam int IW = $clog2(D);
    localparam logic [31:0] BASE = 32'h0004_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_res0 = '0, req_res1 = '0;
    logic [15:0]   req_sqid = '0, req_cid = '0, sq_head = '0;
    logic [7:0]    req_sc = '0;
    logic [2:0]    req_sct = '0;
    logic [1:0]    req_crd = '0;
    logic          req_more = 1'b0, req_dnr = 1'b0;
    logic          db_valid = 1'b0;
    logic [IW-1:0] db_head = '0;
    logic          wr_valid;
    logic [31:0]   wr_addr;
    logic [127:0]  wr_data;

    int tests = 0, fails = 0;
    int m_tail = 0, m_head = 0;
    bit m_phase = 1'b1;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cqw_top #(.DEPTH(D), .ADDR_W(32)) u_cqw_top (
        .clk(clk), .rst_n(rst_n), .cq_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_res0(req_res0), .req_res1(req_res1), .req_sqid(req_sqid),
        .req_cid(req_cid), .req_sc(req_sc), .req_sct(req_sct), .req_crd(req_crd),
        .req_more(req_more), .req_dnr(req_dnr), .sq_head(sq_head),
        .db_valid(db_valid), .db_head(db_head),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: optional post of item n, optional doorbell dbv
    task automatic step(input bit do_post, input int n, input bit do_db, input int dbv, input string tag);
        int occ, adv, occ_new;
        bit acc, dbok;
        logic [127:0] exp;
        occ  = (m_tail - m_head + D) % D;
        acc  = do_post && (occ < D - 1);
        adv  = (dbv - m_head + D) % D;
        dbok = do_db && (dbv < D) && (adv <= occ);
        @(negedge clk);
        req_valid = do_post;
        req_res0  = 32'hA000_0000 + 32'(n);
        req_res1  = ~(32'(n) * 32'h0101_0101);
        req_sqid  = 16'(n * 3 + 1);
        req_cid   = 16'(n * 7 + 5);
        req_sc    = 8'(n * 13);
        req_sct   = 3'(n);
        req_crd   = 2'(n >> 1);
        req_more  = n[0];
        req_dnr   = n[1];
        sq_head   = 16'(n * 11 + 2);
        db_valid  = do_db;
        db_head   = IW'(dbv);
        // R6: ready reflects full state before this edge
        check("R6 ready before edge", 128'(req_ready), 128'(occ < D - 1));
        exp = {req_dnr, req_more, req_crd, req_sct, req_sc, m_phase,
               req_cid, req_sqid, sq_head, req_res1, req_res0};
        @(negedge clk);
        req_valid = 1'b0;
        db_valid  = 1'b0;
        check({tag, " R3 wr_valid"}, 128'(wr_valid), 128'(acc));
        if (acc) begin
            check({tag, " R3/R4 addr"}, 128'(wr_addr), 128'(BASE + 32'(m_tail * 16)));
            check({tag, " R2/R5/R11 data"}, wr_data, exp);
            if (m_tail == D - 1) begin
                m_tail = 0;
                m_phase = ~m_phase;
            end else begin
                m_tail = m_tail + 1;
            end
        end
        if (dbok) m_head = dbv;
        occ_new = (m_tail - m_head + D) % D;
        // R7 R8 R9 R10: ready after the edge follows the model head
        check({tag, " R7 ready after"}, 128'(req_ready), 128'(occ_new < D - 1));
    endtask

    initial begin
        int n = 0;
        #(CLK_PERIOD * 3 + 2);
        // R1 reset state
        check("R1 ready at reset", 128'(req_ready), 128'd1);
        check("R1 wr_valid at reset", 128'(wr_valid), 128'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 first entry to slot 0, phase 1
        step(1, n++, 0, 0, "R1");
        // sweep laps: fill until stalled, then release a varying amount
        for (int lap = 0; lap < 14; lap++) begin
            for (int k = 0; k < D; k++) step(1, n++, 0, 0, "R6 fill");
            // R8: out-of-range doorbells
            step(0, 0, 1, D, "R8");
            step(0, 0, 1, (1 << IW) - 1, "R8");
            step(0, 0, 1, (m_head + 1 + lap % (D - 1)) % D, "R7");
            // R9: doorbell past tail
            step(0, 0, 1, (m_tail + 1) % D, "R9");
            // R10: simultaneous post and doorbell
            step(1, n++, 1, (m_head + 1) % D, "R10");
            step(0, 0, 1, m_tail, "R7 drain");
        end
        // R9 with empty ring: any move rejected
        step(0, 0, 1, (m_head + 2) % D, "R9 empty");
        step(1, n++, 0, 0, "R4");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule